// File: doc/BRIEF.md
# Pad Ring Test Mode Controller

This block sits between the pad ring and the core logic of a chip. When reset is released it samples four test strap pins and fixes one of three operating modes until the next reset: normal operation, a high-impedance mode that releases every pad, or a NAND-tree mode that lets board test equipment check pad continuity. Each pad is modelled by three controls: output enable, output data and pull enable. In normal mode these come straight from the core.

In NAND-tree mode the input buffers of the chain-member pads feed two independent ripple chains of NAND gates. Each chain reports on its own dedicated result pad. Every other output driver is released, except a test output pad that stays under core control. The input buffers are never disabled, so a tester can drive any pad in either test mode. The chain result is purely combinational, so a tester can toggle pads at its own speed without a clock.

The pad vector is laid out as follows: chain A members at indices 0 to L-1 in chain order, chain B members at L to 2L-1, then the spare pads, then the chain A result pad, the chain B result pad and the test output pad. L is the chain length.

Top module: `pad_test_ctrl`

## Requirements
- R1: If the straps read test=1, tck=0, texec=0, ti=1 at the last clock edge before reset is released, `mode_o` reads 1 (high-impedance mode) after release.
- R2: If the straps read test=1, tck=0, texec=1, ti=0 at that edge, `mode_o` reads 2 (NAND-tree mode).
- R3: Any other strap combination gives `mode_o` = 0 (normal mode). In normal mode `pad_oe`, `pad_do` and `pad_pe` equal `core_oe`, `core_do` and `core_pe` bit for bit. `mode_o` never reads 3.
- R4: Strap changes after reset release have no effect on `mode_o` or on the pad controls until the next reset.
- R5: In high-impedance mode every bit of `pad_oe` and `pad_pe` is 0, including the result pads and the test output pad.
- R6: In NAND-tree mode `pad_oe` is 0 for every pad except the two result pads and the test output pad. The test output pad's enable and data follow the core.
- R7: In NAND-tree mode the chain A result pad (index 2L+SPARE) and the chain B result pad (index 2L+SPARE+1) are enabled, and each drives its own chain's result on `pad_do`.
- R8: The chain result depends only on p, the highest 1-based chain position whose pad input is low. With no low input the result is 1 exactly when L is odd. With p=1 it is 1 exactly when L is even. With p≥2 it is 1 exactly when L−p is even.
- R9: The pad inputs of one chain have no effect on the other chain's result pad.
- R10: In NAND-tree mode `pad_pe` equals `core_pe` on every pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| strap_test | input | 1 | Test enable strap |
| strap_tck | input | 1 | Test clock strap, must be low to select a test mode |
| strap_texec | input | 1 | Test execute strap |
| strap_ti | input | 1 | Test input strap |
| chain_pad_in | input | 2*CHAIN_LEN | Input buffer outputs of chain A (low half) and chain B (high half) pads |
| core_oe | input | NUM_PADS | Output enables requested by the core |
| core_do | input | NUM_PADS | Output data from the core |
| core_pe | input | NUM_PADS | Pull enables requested by the core |
| pad_oe | output | NUM_PADS | Output enable to each pad |
| pad_do | output | NUM_PADS | Output data to each pad |
| pad_pe | output | NUM_PADS | Pull enable to each pad |
| mode_o | output | 2 | Latched mode: 0 normal, 1 high-impedance, 2 NAND-tree |

## Verification
The bench builds the block with CHAIN_LEN=18 and SPARE_PADS=2. The even chain length makes the all-high result 0, so a single low pad at an even position or at position 1 flips the output, while one at an odd position of 3 or more leaves it unchanged. Both branches of the position rule are therefore exercised. The two spare pads belong to neither chain, so the bench can confirm that NAND-tree mode releases pads that no chain uses, and that the result pads sit at the offset the spare count implies.

// File: rtl/tmc_pkg.sv
// Shared types for the pad ring test mode controller.
// Assumes: strap pins are already synchronous to clk while reset is held.
package tmc_pkg;

    typedef enum logic [1:0] {
        TM_NORMAL = 2'd0,
        TM_HIGHZ  = 2'd1,
        TM_NTREE  = 2'd2
    } test_mode_e;

    typedef struct packed {
        logic test;
        logic tck;
        logic texec;
        logic ti;
    } strap_t;

    // Map a strap combination onto a mode; anything unlisted is normal.
    function automatic test_mode_e decode_strap(input strap_t s);
        test_mode_e m;
        m = TM_NORMAL;
        if (s.test && !s.tck) begin
            if (!s.texec && s.ti)
                m = TM_HIGHZ;
            else if (s.texec && !s.ti)
                m = TM_NTREE;
        end
        return m;
    endfunction

endpackage

// File: rtl/tmc_strap_latch.sv
// Strap latch: keeps loading the decoded strap mode on every clock edge
// while reset is low and holds the last loaded value once reset is
// released. Assumes the straps are stable around the release edge.
module tmc_strap_latch
    import tmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  strap_t     strap,
    output test_mode_e mode
);

    // Purpose: capture mode during reset, freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= decode_strap(strap);
    end

endmodule

// File: rtl/tmc_nand_chain.sv
// One NAND-tree chain: position 0 passes its pad through, and each later
// position k NANDs the previous stage with pad k. Purely combinational,
// so the tester sets the pace. Assumes LEN >= 2.
module tmc_nand_chain #(
    parameter int LEN = 18
) (
    input  logic [LEN-1:0] taps,
    output logic           result
);

    logic [LEN-1:0] stage;

    // Purpose: ripple the NAND stages in fixed tap order.
    always_comb begin
        stage[0] = taps[0];
        for (int k = 1; k < LEN; k++)
            stage[k] = ~(stage[k-1] & taps[k]);
    end

    assign result = stage[LEN-1];

endmodule

// File: rtl/tmc_pad_mux.sv
// Per-pad control selection. Each pad gets a role from its index: chain A
// result, chain B result, test output, or ordinary pad. Assumes the three
// special indices are distinct and inside the pad range.
module tmc_pad_mux
    import tmc_pkg::*;
#(
    parameter int NUM_PADS = 41,
    parameter int RES_A    = 38,
    parameter int RES_B    = 39,
    parameter int TOUT     = 40
) (
    input  test_mode_e          mode,
    input  logic                res_a,
    input  logic                res_b,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] core_do,
    input  logic [NUM_PADS-1:0] core_pe,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_do,
    output logic [NUM_PADS-1:0] pad_pe
);

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        logic oe_l, do_l, pe_l;

        if (i == RES_A || i == RES_B) begin : g_result
            logic res_l;
            assign res_l = (i == RES_A) ? res_a : res_b;
            // Purpose: result pad drives its chain in NAND-tree mode.
            always_comb begin
                oe_l = core_oe[i];
                do_l = core_do[i];
                pe_l = core_pe[i];
                case (mode)
                    TM_HIGHZ: begin oe_l = 1'b0; do_l = 1'b0; pe_l = 1'b0; end
                    TM_NTREE: begin oe_l = 1'b1; do_l = res_l; end
                    default:  ;
                endcase
            end
        end else if (i == TOUT) begin : g_tout
            // Purpose: test output stays with the core except in high-Z.
            always_comb begin
                oe_l = core_oe[i];
                do_l = core_do[i];
                pe_l = core_pe[i];
                if (mode == TM_HIGHZ) begin
                    oe_l = 1'b0;
                    do_l = 1'b0;
                    pe_l = 1'b0;
                end
            end
        end else begin : g_plain
            // Purpose: ordinary pad floats in both test modes.
            always_comb begin
                oe_l = core_oe[i];
                do_l = core_do[i];
                pe_l = core_pe[i];
                case (mode)
                    TM_HIGHZ: begin oe_l = 1'b0; do_l = 1'b0; pe_l = 1'b0; end
                    TM_NTREE: begin oe_l = 1'b0; do_l = 1'b0; end
                    default:  ;
                endcase
            end
        end

        assign pad_oe[i] = oe_l;
        assign pad_do[i] = do_l;
        assign pad_pe[i] = pe_l;
    end

endmodule

// File: rtl/pad_test_ctrl.sv
// Top of the pad ring test mode controller. Latches the strap mode at
// reset, builds two NAND-tree chains over the chain pad inputs and steers
// the pad controls. Pad order: chain A, chain B, spares, result A,
// result B, test output. Assumes CHAIN_LEN >= 2.
module pad_test_ctrl
    import tmc_pkg::*;
#(
    parameter  int CHAIN_LEN  = 18,
    parameter  int SPARE_PADS = 2,
    localparam int RES_A      = 2 * CHAIN_LEN + SPARE_PADS,
    localparam int RES_B      = RES_A + 1,
    localparam int TOUT       = RES_A + 2,
    localparam int NUM_PADS   = RES_A + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_test,
    input  logic                   strap_tck,
    input  logic                   strap_texec,
    input  logic                   strap_ti,
    input  logic [2*CHAIN_LEN-1:0] chain_pad_in,
    input  logic [NUM_PADS-1:0]    core_oe,
    input  logic [NUM_PADS-1:0]    core_do,
    input  logic [NUM_PADS-1:0]    core_pe,
    output logic [NUM_PADS-1:0]    pad_oe,
    output logic [NUM_PADS-1:0]    pad_do,
    output logic [NUM_PADS-1:0]    pad_pe,
    output logic [1:0]             mode_o
);

    strap_t     strap;
    test_mode_e mode;
    logic [1:0] chain_res;

    assign strap = '{test: strap_test, tck: strap_tck,
                     texec: strap_texec, ti: strap_ti};

    tmc_strap_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (strap),
        .mode  (mode)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chain
        tmc_nand_chain #(.LEN(CHAIN_LEN)) u_chain (
            .taps   (chain_pad_in[c*CHAIN_LEN +: CHAIN_LEN]),
            .result (chain_res[c])
        );
    end

    tmc_pad_mux #(
        .NUM_PADS (NUM_PADS),
        .RES_A    (RES_A),
        .RES_B    (RES_B),
        .TOUT     (TOUT)
    ) u_mux (
        .mode    (mode),
        .res_a   (chain_res[0]),
        .res_b   (chain_res[1]),
        .core_oe (core_oe),
        .core_do (core_do),
        .core_pe (core_pe),
        .pad_oe  (pad_oe),
        .pad_do  (pad_do),
        .pad_pe  (pad_pe)
    );

    assign mode_o = mode;

endmodule

// File: rtl/tmc_checker.sv
// Property checker for pad_test_ctrl, attached by bind. Observes ports only.
module tmc_checker #(
    parameter  int CHAIN_LEN  = 18,
    parameter  int SPARE_PADS = 2,
    localparam int RES_A      = 2 * CHAIN_LEN + SPARE_PADS,
    localparam int NUM_PADS   = RES_A + 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PADS-1:0] core_oe,
    input logic [NUM_PADS-1:0] core_do,
    input logic [NUM_PADS-1:0] core_pe,
    input logic [NUM_PADS-1:0] pad_oe,
    input logic [NUM_PADS-1:0] pad_do,
    input logic [NUM_PADS-1:0] pad_pe,
    input logic [1:0]          mode_o
);

    localparam logic [NUM_PADS-1:0] KEEP = {3'b111, {(NUM_PADS-3){1'b0}}};

    p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    p_normal_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd0 |-> (pad_oe == core_oe && pad_do == core_do && pad_pe == core_pe));

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));

    p_highz_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd1 |-> (pad_oe == '0 && pad_pe == '0));

    p_ntree_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd2 |-> ((pad_oe & ~KEEP) == '0));

    p_ntree_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd2 |-> (pad_oe[RES_A] && pad_oe[RES_A+1]));

    p_ntree_pulls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd2 |-> pad_pe == core_pe);

endmodule

bind pad_test_ctrl tmc_checker #(
    .CHAIN_LEN  (CHAIN_LEN),
    .SPARE_PADS (SPARE_PADS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_oe (core_oe),
    .core_do (core_do),
    .core_pe (core_pe),
    .pad_oe  (pad_oe),
    .pad_do  (pad_do),
    .pad_pe  (pad_pe),
    .mode_o  (mode_o)
);

// File: tb/pad_test_ctrl_bench.sv
// Directed bench for pad_test_ctrl: one task per scenario.
module pad_test_ctrl_bench;

    localparam int L     = 18;
    localparam int SP    = 2;
    localparam int RES_A = 2 * L + SP;
    localparam int RES_B = RES_A + 1;
    localparam int TOUT  = RES_A + 2;
    localparam int NP    = RES_A + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_test = 1'b0, s_tck = 1'b0, s_texec = 1'b0, s_ti = 1'b0;
    logic [2*L-1:0] chain_in = '1;
    logic [NP-1:0] core_oe = '0, core_do = '0, core_pe = '0;
    logic [NP-1:0] pad_oe, pad_do, pad_pe;
    logic [1:0]    mode_o;

    int n_checks = 0;
    int n_err    = 0;

    always #4 clk = ~clk;

    pad_test_ctrl #(.CHAIN_LEN(L), .SPARE_PADS(SP)) u_pad_test_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_test   (s_test),
        .strap_tck    (s_tck),
        .strap_texec  (s_texec),
        .strap_ti     (s_ti),
        .chain_pad_in (chain_in),
        .core_oe      (core_oe),
        .core_do      (core_do),
        .core_pe      (core_pe),
        .pad_oe       (pad_oe),
        .pad_do       (pad_do),
        .pad_pe       (pad_pe),
        .mode_o       (mode_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Result expected from R8, found from the highest low position.
    function automatic bit rule(input logic [L-1:0] v);
        int p;
        p = 0;
        for (int k = 0; k < L; k++)
            if (!v[k]) p = k + 1;
        if (p == 0) return (L % 2) == 1;
        if (p == 1) return (L % 2) == 0;
        return ((L - p) % 2) == 0;
    endfunction

    // Reset with given straps, release, then scramble straps (R4).
    task automatic do_reset(input logic [3:0] s);
        @(negedge clk);
        {s_test, s_tck, s_texec, s_ti} = s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        {s_test, s_tck, s_texec, s_ti} = ~s;
        @(negedge clk);
        #1;
    endtask

    task automatic test_default_reset();
        do_reset(4'b0000);
        check(mode_o == 2'd0, "R3", "reset mode", longint'(mode_o), 0);
        core_oe = {NP{1'b1}} ^ (NP'(1) << 5);
        core_do = {(NP/2){2'b10}} ^ NP'(0);
        core_pe = NP'(41'h0AA_5555_33CC);
        #1;
        check(pad_oe == core_oe, "R3", "normal oe", longint'(pad_oe), longint'(core_oe));
        check(pad_do == core_do, "R3", "normal do", longint'(pad_do), longint'(core_do));
        check(pad_pe == core_pe, "R3", "normal pe", longint'(pad_pe), longint'(core_pe));
    endtask

    task automatic test_decode_all();
        for (int s = 0; s < 16; s++) begin
            logic [1:0] exp_m;
            exp_m = (s == 4'b1001) ? 2'd1 : (s == 4'b1010) ? 2'd2 : 2'd0;
            do_reset(4'(s));
            if (s == 4'b1001)
                check(mode_o == exp_m, "R1", "decode highz", longint'(mode_o), longint'(exp_m));
            else if (s == 4'b1010)
                check(mode_o == exp_m, "R2", "decode ntree", longint'(mode_o), longint'(exp_m));
            else
                check(mode_o == exp_m, "R3", "decode other", longint'(mode_o), longint'(exp_m));
        end
    endtask

    task automatic test_latch_hold();
        do_reset(4'b1010);
        @(negedge clk);
        {s_test, s_tck, s_texec, s_ti} = 4'b1001;
        repeat (5) @(negedge clk);
        #1;
        check(mode_o == 2'd2, "R4", "mode held", longint'(mode_o), 2);
        core_oe = '1;
        #1;
        check(pad_oe == (NP'(7) << RES_A), "R4", "oe after strap change",
              longint'(pad_oe), longint'(NP'(7) << RES_A));
    endtask

    task automatic test_highz();
        do_reset(4'b1001);
        core_oe = '1; core_pe = '1; core_do = '1;
        #1;
        check(mode_o == 2'd1, "R5", "mode", longint'(mode_o), 1);
        check(pad_oe == '0, "R5", "all oe off", longint'(pad_oe), 0);
        check(pad_pe == '0, "R5", "all pulls off", longint'(pad_pe), 0);
    endtask

    task automatic test_ntree_enables();
        do_reset(4'b1010);
        core_oe = '1; core_pe = NP'(41'h155_0F0F_1234); core_do = '0;
        #1;
        check(pad_oe == (NP'(7) << RES_A), "R6", "only kept pads enabled",
              longint'(pad_oe), longint'(NP'(7) << RES_A));
        check(pad_pe == core_pe, "R10", "pulls follow core", longint'(pad_pe), longint'(core_pe));
        core_do[TOUT] = 1'b1;
        #1;
        check(pad_do[TOUT] == 1'b1, "R6", "tout data high", longint'(pad_do[TOUT]), 1);
        core_do[TOUT] = 1'b0; core_oe[TOUT] = 1'b0;
        #1;
        check(pad_do[TOUT] == 1'b0, "R6", "tout data low", longint'(pad_do[TOUT]), 0);
        check(pad_oe[TOUT] == 1'b0, "R6", "tout oe follows core", longint'(pad_oe[TOUT]), 0);
        check(pad_oe[RES_A] && pad_oe[RES_B], "R7", "result pads enabled",
              longint'(pad_oe[RES_B:RES_A]), 3);
        core_oe = '1;
    endtask

    // Walk one low pad along each chain; other chain stays all high.
    task automatic test_chain_walk();
        logic [L-1:0] v;
        bit e;
        for (int c = 0; c < 2; c++) begin
            for (int j = 0; j <= L; j++) begin
                v = '1;
                if (j < L) v[j] = 1'b0;
                chain_in = '1;
                chain_in[c*L +: L] = v;
                #1;
                e = rule(v);
                if (c == 0) begin
                    check(pad_do[RES_A] == e, "R7", "chain A walk", longint'(pad_do[RES_A]), longint'(e));
                    check(pad_do[RES_B] == rule('1), "R9", "chain B untouched",
                          longint'(pad_do[RES_B]), longint'(rule('1)));
                end else begin
                    check(pad_do[RES_B] == e, "R7", "chain B walk", longint'(pad_do[RES_B]), longint'(e));
                    check(pad_do[RES_A] == rule('1), "R9", "chain A untouched",
                          longint'(pad_do[RES_A]), longint'(rule('1)));
                end
            end
        end
    endtask

    // Pseudo-random patterns on both chains against the position rule.
    task automatic test_chain_patterns();
        logic [31:0] x;
        x = 32'h1357_9BDF;
        for (int n = 0; n < 60; n++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            chain_in = {x[31:14], x[17:0]};
            if (n % 4 == 0) chain_in[L-1] = 1'b1;
            if (n % 4 == 1) chain_in[2*L-1] = 1'b1;
            #1;
            check(pad_do[RES_A] == rule(chain_in[L-1:0]), "R8", "chain A pattern",
                  longint'(pad_do[RES_A]), longint'(rule(chain_in[L-1:0])));
            check(pad_do[RES_B] == rule(chain_in[2*L-1:L]), "R8", "chain B pattern",
                  longint'(pad_do[RES_B]), longint'(rule(chain_in[2*L-1:L])));
        end
        chain_in = '1;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        test_default_reset();
        test_decode_all();
        test_latch_hold();
        test_highz();
        test_ntree_enables();
        test_chain_walk();
        test_chain_patterns();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule